// File: doc/BRIEF.md
# Single-Precision Floating-Point Ordering Comparator

This block takes two 32-bit single-precision floating-point words and reports how the first orders against the second. It raises exactly one of four flags: less, equal, greater or unordered. The result lands in a register one clock after the operands are offered, and a valid strobe travels with it. This lets the block sit inside a pipeline with a fixed latency of one.

The ordering rests on the layout of the format. The exponent sits above the fraction and is biased, so the low 31 bits of two non-negative numbers order correctly when they are read as plain unsigned integers. A single unsigned compare of those bits gives the magnitude order. The sign bits then steer that result: opposite signs decide the result directly, and the magnitude result is mirrored when both operands are negative. Zeros of either sign are equal. A NaN on either side makes the pair unordered.

Each operand is also split into its sign, its unbiased exponent and its significand with the hidden bit restored. These fields appear on a debug port, registered alongside the flags.

Top module: `fp32_order_cmp`

## Requirements
- R1: Bit 31 is the sign, bits 30:23 the biased exponent E and bits 22:0 the fraction F. The debug port shows the sign, the unbiased exponent E-127 as a 9-bit two's complement value, and the 24-bit significand {E!=0, F}.
- R2: When the signs differ and the pair is neither NaN nor a pair of zeros, the operand with sign 1 (negative) orders below the one with sign 0 (positive).
- R3: When both operands are positive, the order is the unsigned order of bits 30:0. A larger exponent wins, and equal exponents defer to the fraction. Example: 0x3F000000 (one half, E=126) is less than 0x40000000 (two, E=128).
- R4: When both operands are negative, the order is the reverse of the unsigned order of bits 30:0.
- R5: +0 (0x00000000) and -0 (0x80000000) compare equal, in any pairing.
- R6: A word with E=255 and F!=0 is NaN. If either operand is NaN, unord is 1 and lt, eq and gt are 0. E=255 with F=0 (infinity) orders like any other value.
- R7: out_valid is in_valid delayed by one clock. The flags and debug fields shown with out_valid belong to the operands presented on the preceding edge.
- R8: Whenever out_valid is 1, exactly one of lt, eq, gt and unord is 1. Two identical non-NaN words give eq.
- R9: While rst_n is low, out_valid and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands a_i and b_i are presented |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| out_valid | output | 1 | Result registers hold a fresh result |
| lt_o | output | 1 | a orders below b |
| eq_o | output | 1 | a equals b |
| gt_o | output | 1 | a orders above b |
| unord_o | output | 1 | At least one operand is NaN |
| dbg_a_sign | output | 1 | Sign of a |
| dbg_a_exp | output | 9 | Unbiased exponent of a |
| dbg_a_sig | output | 24 | Significand of a with hidden bit |
| dbg_b_sign | output | 1 | Sign of b |
| dbg_b_exp | output | 9 | Unbiased exponent of b |
| dbg_b_sig | output | 24 | Significand of b with hidden bit |

## Verification
NaN detection and the sign correction act on the same operands in the same cycle. A negative NaN against a positive number, or a NaN against a signed zero, invites the sign path to claim "less" or "equal" while the NaN path must claim "unordered". The bench provokes these collisions with directed pairs and with random words biased toward exponent 255 and zero. Each result is judged against a reference model that sorts by a monotone integer key, with NaN screened out first.

// File: rtl/fp32_order_cmp.sv
module fp32_order_cmp #(
  parameter int W    = 32,
  parameter int EW   = 8,
  parameter int BIAS = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic          out_valid,
  output logic          lt_o,
  output logic          eq_o,
  output logic          gt_o,
  output logic          unord_o,
  output logic          dbg_a_sign,
  output logic [EW:0]   dbg_a_exp,
  output logic [W-EW-1:0] dbg_a_sig,
  output logic          dbg_b_sign,
  output logic [EW:0]   dbg_b_exp,
  output logic [W-EW-1:0] dbg_b_sig
);
  localparam int FW = W - EW - 1;
  localparam logic [EW-1:0] EMAX = '1;

  logic [W-2:0] mag_a, mag_b;
  logic         sa, sb, nan_a, nan_b, both_zero, mag_lt, mag_eq;
  logic         c_lt, c_eq, c_gt, c_un;

  assign sa    = a_i[W-1];
  assign sb    = b_i[W-1];
  assign mag_a = a_i[W-2:0];
  assign mag_b = b_i[W-2:0];
  assign nan_a = (a_i[W-2:FW] == EMAX) && (a_i[FW-1:0] != '0);
  assign nan_b = (b_i[W-2:FW] == EMAX) && (b_i[FW-1:0] != '0);
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    c_un = nan_a | nan_b;
    c_lt = 1'b0;
    c_eq = 1'b0;
    c_gt = 1'b0;
    if (!c_un) begin
      if (both_zero)      c_eq = 1'b1;
      else if (sa != sb) begin
        c_lt = sa;
        c_gt = sb;
      end else if (mag_eq) c_eq = 1'b1;
      else begin
        c_lt = mag_lt ^ sa;
        c_gt = ~(mag_lt ^ sa);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      {lt_o, eq_o, gt_o, unord_o} <= '0;
      {dbg_a_sign, dbg_a_exp, dbg_a_sig} <= '0;
      {dbg_b_sign, dbg_b_exp, dbg_b_sig} <= '0;
    end else begin
      out_valid <= in_valid;
      {lt_o, eq_o, gt_o, unord_o} <= {c_lt, c_eq, c_gt, c_un};
      dbg_a_sign <= sa;
      dbg_b_sign <= sb;
      dbg_a_exp  <= {1'b0, a_i[W-2:FW]} - (EW+1)'(BIAS);
      dbg_b_exp  <= {1'b0, b_i[W-2:FW]} - (EW+1)'(BIAS);
      dbg_a_sig  <= {a_i[W-2:FW] != '0, a_i[FW-1:0]};
      dbg_b_sig  <= {b_i[W-2:FW] != '0, b_i[FW-1:0]};
    end
  end
endmodule

// File: rtl/fp32_order_cmp_chk.sv
module fp32_order_cmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic        out_valid,
  input logic        lt_o,
  input logic        eq_o,
  input logic        gt_o,
  input logic        unord_o,
  input logic [23:0] dbg_a_sig
);
  logic a_nan, b_nan;
  assign a_nan = a_i[30:23] == 8'hFF && a_i[22:0] != 0;
  assign b_nan = b_i[30:23] == 8'hFF && b_i[22:0] != 0;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R7
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $countones({lt_o, eq_o, gt_o, unord_o}) == 1); // R8
  AST_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (a_nan || b_nan)) |=> (unord_o && !lt_o && !eq_o && !gt_o)); // R6
  AST_NEG_BELOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && a_i[31] && !b_i[31] && !a_nan && !b_nan && (a_i[30:0] != 0 || b_i[30:0] != 0)) |=> lt_o); // R2
  AST_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && a_i[30:0] == 0 && b_i[30:0] == 0) |=> eq_o); // R5
  AST_HIDDEN_BIT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> dbg_a_sig[23] == ($past(a_i[30:23]) != 0)); // R1
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid && !unord_o); // R9
endmodule

bind fp32_order_cmp fp32_order_cmp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
  .out_valid(out_valid), .lt_o(lt_o), .eq_o(eq_o), .gt_o(gt_o),
  .unord_o(unord_o), .dbg_a_sig(dbg_a_sig)
);

// File: tb/fp32_order_cmp_tb_top.sv
module fp32_order_cmp_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic out_valid, lt, eq, gt, un, as, bs;
  logic [8:0] ae, be;
  logic [23:0] asg, bsg;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  fp32_order_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_i(a), .b_i(b),
    .out_valid(out_valid), .lt_o(lt), .eq_o(eq), .gt_o(gt), .unord_o(un),
    .dbg_a_sign(as), .dbg_a_exp(ae), .dbg_a_sig(asg),
    .dbg_b_sign(bs), .dbg_b_exp(be), .dbg_b_sig(bsg)
  );

  function automatic bit is_nan(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic [31:0] order_key(logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31]) return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic logic [3:0] ref_flags(logic [31:0] x, logic [31:0] y);
    logic [31:0] kx, ky;
    if (is_nan(x) || is_nan(y)) return 4'b0001;
    kx = order_key(x);
    ky = order_key(y);
    if (kx < ky) return 4'b1000;
    if (kx > ky) return 4'b0010;
    return 4'b0100;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, string tag);
    logic [3:0] e;
    logic [8:0] ex;
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    e = ref_flags(x, y);
    chk(out_valid === 1'b1, "R7 valid", 64'(out_valid), 64'd1);
    chk({lt, eq, gt, un} === e, tag, 64'({lt, eq, gt, un}), 64'(e));
    ex = {1'b0, x[30:23]} - 9'd127;
    chk({as, ae, asg} === {x[31], ex, x[30:23] != 8'd0, x[22:0]}, "R1 decode a",
        64'({as, ae, asg}), 64'({x[31], ex, x[30:23] != 8'd0, x[22:0]}));
    ex = {1'b0, y[30:23]} - 9'd127;
    chk({bs, be, bsg} === {y[31], ex, y[30:23] != 8'd0, y[22:0]}, "R1 decode b",
        64'({bs, be, bsg}), 64'({y[31], ex, y[30:23] != 8'd0, y[22:0]}));
  endtask

  function automatic logic [31:0] rnd_word();
    logic [31:0] w = $urandom;
    case ($urandom % 6)
      0: w[30:23] = 8'hFF;
      1: w[30:0] = '0;
      2: w[30:23] = 8'(126 + ($urandom % 3));
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk({out_valid, lt, eq, gt, un} === 5'b0, "R9 reset", 64'({out_valid, lt, eq, gt, un}), 64'd0);
    rst_n = 1'b1;
    apply(32'h3F00_0000, 32'h4000_0000, "R3 half<two");
    chk(lt === 1'b1, "R3 half lt", 64'(lt), 64'd1);
    apply(32'h4000_0000, 32'h3F00_0000, "R3 two>half");
    apply(32'h3F80_0001, 32'h3F80_0000, "R3 fraction");
    apply(32'hBF00_0000, 32'hC000_0000, "R4 -half>-two");
    chk(gt === 1'b1, "R4 neg gt", 64'(gt), 64'd1);
    apply(32'hC000_0000, 32'hBF80_0000, "R4 -two<-one");
    apply(32'hBF80_0000, 32'h3F80_0000, "R2 -1<1");
    apply(32'h0000_0001, 32'h8000_0001, "R2 tiny");
    apply(32'h0000_0000, 32'h8000_0000, "R5 +0=-0");
    chk(eq === 1'b1, "R5 eq", 64'(eq), 64'd1);
    apply(32'h8000_0000, 32'h0000_0000, "R5 -0=+0");
    apply(32'h8000_0000, 32'h0000_0001, "R2 -0<min");
    apply(32'h7FC0_0000, 32'h3F80_0000, "R6 nan a");
    apply(32'hFF80_0001, 32'h0000_0000, "R6 negnan vs zero");
    chk(un === 1'b1 && lt === 1'b0, "R6 unord", 64'({un, lt}), 64'b10);
    apply(32'h8000_0000, 32'hFFFF_FFFF, "R6 zero vs negnan");
    apply(32'h7F80_0000, 32'h7F7F_FFFF, "R6 inf ordered");
    apply(32'hFF80_0000, 32'hFF80_0000, "R8 -inf eq");
    apply(32'h4049_0FDB, 32'h4049_0FDB, "R8 same");
    for (int i = 0; i < 3000; i++) apply(rnd_word(), rnd_word(), "R8 random");
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 idle", 64'(out_valid), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule